// File: doc/BRIEF.md
# Serial LED Matrix Scan Driver

This block refreshes an LED matrix that hangs off a chain of external serial-in, parallel-out shift registers. It divides the system clock down to a gated shift clock. In each slot it pushes one 24-bit word, made of row data and one-hot column-select bits, out on a serial data pin. It then pulses a latch pin so that the external registers present the word to the LEDs. The word stays on the LEDs for a programmable number of further slots before the next column is scanned.

Two geometries are supported. One has eight columns of eight rows. The other has four columns of sixteen rows, which leaves four select-chain bits free. A 24-bit inversion mask flips chosen word bits. Dedicated LED bits then replace the top select bits with static values. In single-LED mode each column is lit one row at a time. A clear command, accepted only while the block is stopped, pushes one all-zero word. The frame data and configuration are plain inputs and are held static while the block runs.

Top module: `ledscan_drv`

## Requirements
- R1: After reset the three pins read 0. Whenever the block is stopped, the clock pin sits at `pol_sck`, the data pin at `pol_sd` and the latch pin at `pol_lat`.
- R2: One output clock period lasts 2*(`div_val`+1) system cycles. A slot is 32 output periods. Consecutive latch pulses are (`hold_slots`+1)*64*(`div_val`+1) cycles apart.
- R3: Each word is 24 bits, sent MSB first, one bit per rising edge of the (polarity-corrected) clock. In 8x8 mode (`geom16`=0): bits [23:16] are the low byte of the column entry, bits [15:8] are the one-hot select with column c at bit 8+c, and bits [7:0] are 0. In 16x4 mode: bits [23:8] are the column entry and bits [7:0] are the select with column c at bit c.
- R4: Columns are scanned in ascending order from 0. Column c takes entry `frame_data[16c+15:16c]`. The column count is 8-k in 8x8 mode and min(4, 8-k) in 16x4 mode, where k is `ded_cnt`. After the last column, scanning returns to column 0.
- R5: The word is XORed with `inv_mask`. In 8x8 mode, mask bits [7:0] have no effect.
- R6: With k = `ded_cnt` from 1 to 6, the top k bits of the select byte take their values from the same positions of `ded_val`, after inversion. Those are bits [15:16-k] in 8x8 mode and bits [7:8-k] in 16x4 mode. With k=7 the whole word comes from `ded_val` and one step is scanned.
- R7: With `single_led`=1, each column is shown as 8 (8x8) or 16 (16x4) successive steps. Step s keeps only data bit s of the entry, starting at bit 0. All other behaviour is the same.
- R8: The latch is active for exactly one output period, the one after the 24th rising clock edge. The clock pin has no edges outside the 24 shift periods.
- R9: While `chg_dly` < `div_val`, the data pin changes exactly `chg_dly`+1 cycles after a falling clock edge.
- R10: Dropping `run_en` lets the current frame finish through its last column and hold slots. No further word is sent after that.
- R11: A `clr_req` pulse while stopped sends one word of 24 zeros, ignoring the inversion mask, the dedicated bits and `run_en`, and the block then stops by itself. A `clr_req` while running has no effect.
- R12: Setting `pol_sck`, `pol_sd` or `pol_lat` inverts the corresponding pin. The logical word decoded from the pins is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Scan enable; when dropped, the frame in progress completes |
| clr_req | input | 1 | One-cycle request to push an all-zero word while stopped |
| geom16 | input | 1 | 0: 8 columns x 8 rows, 1: 4 columns x 16 rows |
| single_led | input | 1 | 1: light one row bit of a column at a time |
| ded_cnt | input | 3 | Number of top select bits used as dedicated LEDs (7 = whole word) |
| ded_val | input | 24 | Values for dedicated LED bits |
| inv_mask | input | 24 | Per-bit inversion of the shifted word |
| div_val | input | 16 | Clock divider; output period 2*(div_val+1) cycles |
| chg_dly | input | 4 | Data change delay after the clock fall, in cycles minus one |
| hold_slots | input | 4 | Extra slots each word is held after its shift slot |
| frame_data | input | 128 | Eight 16-bit column entries |
| pol_sck | input | 1 | Clock pin inversion |
| pol_sd | input | 1 | Data pin inversion |
| pol_lat | input | 1 | Latch pin inversion |
| sck_o | output | 1 | Shift clock pin |
| sd_o | output | 1 | Serial data pin |
| lat_o | output | 1 | Latch strobe pin |

## Verification
The pins are registered once, so every pin event trails the internal schedule by one cycle. All three pins share that lag, so intervals measured between them are exact. The bench samples the pins on the falling system clock edge and rebuilds each word the way an external register chain would: it shifts on each rising clock and captures the word at the rising latch edge. It then compares the latch-to-latch gap with (hold+1)*64*(div+1) cycles, the latch width with 2*(div+1) cycles, and the lag from clock fall to data change with `chg_dly`+1 cycles. After `run_en` drops, the bench waits a full frame plus three steps before counting words. That wait makes the stop and clear checks see any extra word that would have arrived late.

// File: rtl/ledscan_pkg.sv
package ledscan_pkg;
  localparam int SEL_W    = 8;
  localparam int ROW_W    = 2 * SEL_W;
  localparam int WORD_W   = SEL_W + ROW_W;
  localparam int SLOT_LEN = 32;
  localparam int PCNT_W   = $clog2(SLOT_LEN);
  localparam int COL_W    = $clog2(SEL_W);
  localparam int CC_W     = COL_W + 1;
  localparam int SUB_W    = $clog2(ROW_W);
  localparam int SC_W     = SUB_W + 1;
  localparam int FRAME_W  = SEL_W * ROW_W;

  typedef logic [WORD_W-1:0] word_t;

  // number of select lines actually scanned
  function automatic logic [CC_W-1:0] col_count(input logic geom16, input logic [COL_W-1:0] k);
    if (k == '1) return CC_W'(1);
    if (geom16 && (CC_W'(k) <= CC_W'(SEL_W / 2))) return CC_W'(SEL_W / 2);
    return CC_W'(SEL_W) - CC_W'(k);
  endfunction

  // steps per column: one, or one per row bit in single-LED mode
  function automatic logic [SC_W-1:0] sub_count(input logic geom16, input logic single);
    if (!single) return SC_W'(1);
    return geom16 ? SC_W'(ROW_W) : SC_W'(SEL_W);
  endfunction

  // word positions taken over by dedicated LED values
  function automatic word_t ded_mask(input logic geom16, input logic [COL_W-1:0] k);
    logic [SEL_W-1:0] top;
    if (k == '1) return '1;
    top = ~({SEL_W{1'b1}} >> k);
    return geom16 ? word_t'(top) : (word_t'(top) << SEL_W);
  endfunction

  function automatic word_t build_word(input logic geom16, input logic single,
                                       input logic [COL_W-1:0] k, input logic [COL_W-1:0] col,
                                       input logic [SUB_W-1:0] sub, input logic [ROW_W-1:0] entry,
                                       input word_t inv, input word_t ded);
    logic [ROW_W-1:0] d;
    logic [SEL_W-1:0] sel;
    word_t raw, im, dm;
    d   = single ? (entry & (ROW_W'(1) << sub)) : entry;
    sel = SEL_W'(1) << col;
    if (geom16) begin
      raw = {d, sel};
      im  = inv;
    end else begin
      raw = {d[SEL_W-1:0], sel, {SEL_W{1'b0}}};
      im  = inv & ~word_t'({SEL_W{1'b1}});
    end
    dm = ded_mask(geom16, k);
    return ((raw ^ im) & ~dm) | (ded & dm);
  endfunction
endpackage

// File: rtl/ledscan_clkgen.sv
module ledscan_clkgen #(
  parameter int DIV_W = 16,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  input  logic [DLY_W-1:0] chg_dly,
  output logic             ph,
  output logic             fall_evt,
  output logic             upd
);
  logic [DIV_W-1:0] dcnt;
  logic [DLY_W-1:0] dly;
  logic             pend;
  logic             tick;

  assign tick     = (dcnt == div_val);
  assign fall_evt = run && tick && ph;
  assign upd      = pend && (dly == '0);

  // half-period counter; parks in the high half while stopped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= '0;
      ph   <= 1'b1;
    end else if (!run) begin
      dcnt <= '0;
      ph   <= 1'b1;
    end else if (tick) begin
      dcnt <= '0;
      ph   <= ~ph;
    end else begin
      dcnt <= dcnt + 1'b1;
    end
  end

  // data update fires chg_dly+1 cycles after each internal fall
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      dly  <= '0;
    end else if (!run) begin
      pend <= 1'b0;
    end else if (fall_evt) begin
      pend <= 1'b1;
      dly  <= chg_dly;
    end else if (pend) begin
      if (dly == '0) pend <= 1'b0;
      else           dly  <= dly - 1'b1;
    end
  end
endmodule

// File: rtl/ledscan_seq.sv
module ledscan_seq
  import ledscan_pkg::*;
#(
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              clr_req,
  input  logic              fall_evt,
  input  logic              geom16,
  input  logic              single,
  input  logic [COL_W-1:0]  ded_cnt,
  input  logic [HOLD_W-1:0] hold_slots,
  output logic              busy,
  output logic              clr_act,
  output logic              shift_slot,
  output logic              slot_end,
  output logic [PCNT_W-1:0] pcnt,
  output logic [COL_W-1:0]  col,
  output logic [SUB_W-1:0]  sub
);
  logic              warm;
  logic [HOLD_W-1:0] scnt;
  logic [CC_W-1:0]   ncols;
  logic [SC_W-1:0]   nsub;
  logic              last_col, last_sub;

  assign ncols      = col_count(geom16, ded_cnt);
  assign nsub       = sub_count(geom16, single);
  assign last_col   = ({1'b0, col} == ncols - 1'b1);
  assign last_sub   = ({1'b0, sub} == nsub - 1'b1);
  assign slot_end   = fall_evt && (pcnt == PCNT_W'(SLOT_LEN - 1));
  assign shift_slot = busy && !warm && (scnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      clr_act <= 1'b0;
      warm    <= 1'b1;
      pcnt    <= PCNT_W'(SLOT_LEN - 1);
      scnt    <= '0;
      col     <= '0;
      sub     <= '0;
    end else if (!busy) begin
      warm <= 1'b1;
      pcnt <= PCNT_W'(SLOT_LEN - 1);
      scnt <= '0;
      col  <= '0;
      sub  <= '0;
      if (clr_req) begin
        busy    <= 1'b1;
        clr_act <= 1'b1;
      end else if (run_en) begin
        busy <= 1'b1;
      end
    end else begin
      if (fall_evt) pcnt <= pcnt + 1'b1;
      if (slot_end) begin
        if (warm) begin
          warm <= 1'b0;
        end else if (clr_act) begin
          busy    <= 1'b0;
          clr_act <= 1'b0;
        end else if (scnt == hold_slots) begin
          scnt <= '0;
          if (last_col && last_sub) begin
            col <= '0;
            sub <= '0;
            if (!run_en) busy <= 1'b0;
          end else if (last_sub) begin
            sub <= '0;
            col <= col + 1'b1;
          end else begin
            sub <= sub + 1'b1;
          end
        end else begin
          scnt <= scnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ledscan_ser.sv
module ledscan_ser
  import ledscan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              shift_slot,
  input  logic              clr_act,
  input  logic              ph,
  input  logic              upd,
  input  logic [PCNT_W-1:0] pcnt,
  input  word_t             word,
  input  logic              pol_sck,
  input  logic              pol_sd,
  input  logic              pol_lat,
  output logic              sck_int,
  output logic              lat_int,
  output logic              sck_o,
  output logic              sd_o,
  output logic              lat_o
);
  word_t shreg;

  assign sck_int = shift_slot && ph && (pcnt < PCNT_W'(WORD_W));
  assign lat_int = shift_slot && (pcnt == PCNT_W'(WORD_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 shreg <= '0;
    else if (!busy)                             shreg <= '0;
    else if (upd && shift_slot && pcnt == '0)   shreg <= clr_act ? '0 : word;
    else if (upd)                               shreg <= {shreg[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_o <= 1'b0;
      sd_o  <= 1'b0;
      lat_o <= 1'b0;
    end else begin
      sck_o <= sck_int ^ pol_sck;
      sd_o  <= shreg[WORD_W-1] ^ pol_sd;
      lat_o <= lat_int ^ pol_lat;
    end
  end
endmodule

// File: rtl/ledscan_drv.sv
module ledscan_drv
  import ledscan_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DLY_W  = 4,
  parameter int HOLD_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic               clr_req,
  input  logic               geom16,
  input  logic               single_led,
  input  logic [COL_W-1:0]   ded_cnt,
  input  logic [WORD_W-1:0]  ded_val,
  input  logic [WORD_W-1:0]  inv_mask,
  input  logic [DIV_W-1:0]   div_val,
  input  logic [DLY_W-1:0]   chg_dly,
  input  logic [HOLD_W-1:0]  hold_slots,
  input  logic [FRAME_W-1:0] frame_data,
  input  logic               pol_sck,
  input  logic               pol_sd,
  input  logic               pol_lat,
  output logic               sck_o,
  output logic               sd_o,
  output logic               lat_o
);
  logic              busy, clr_act, shift_slot, slot_end;
  logic              ph, fall_evt, upd;
  logic              sck_int, lat_int;
  logic [PCNT_W-1:0] pcnt;
  logic [COL_W-1:0]  col;
  logic [SUB_W-1:0]  sub;
  word_t             word;

  assign word = build_word(geom16, single_led, ded_cnt, col, sub,
                           frame_data[col*ROW_W +: ROW_W], inv_mask, ded_val);

  ledscan_clkgen #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .div_val(div_val), .chg_dly(chg_dly),
    .ph(ph), .fall_evt(fall_evt), .upd(upd));

  ledscan_seq #(.HOLD_W(HOLD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .clr_req(clr_req), .fall_evt(fall_evt),
    .geom16(geom16), .single(single_led), .ded_cnt(ded_cnt), .hold_slots(hold_slots),
    .busy(busy), .clr_act(clr_act), .shift_slot(shift_slot), .slot_end(slot_end),
    .pcnt(pcnt), .col(col), .sub(sub));

  ledscan_ser u_ser (
    .clk(clk), .rst_n(rst_n), .busy(busy), .shift_slot(shift_slot), .clr_act(clr_act),
    .ph(ph), .upd(upd), .pcnt(pcnt), .word(word),
    .pol_sck(pol_sck), .pol_sd(pol_sd), .pol_lat(pol_lat),
    .sck_int(sck_int), .lat_int(lat_int), .sck_o(sck_o), .sd_o(sd_o), .lat_o(lat_o));
endmodule

module ledscan_chk #(
  parameter int DIV_W = 16,
  parameter int DLY_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             clr_act,
  input logic             slot_end,
  input logic             sck_int,
  input logic             lat_int,
  input logic             ph,
  input logic             upd,
  input logic [DIV_W-1:0] div_val,
  input logic [DLY_W-1:0] chg_dly
);
  // R8
  latch_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lat_int) |=> lat_int);

  // R8
  latch_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lat_int) |-> $past(ph) && !$past(lat_int));

  // R11
  clr_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_act) |-> $past(!busy));

  // R10
  stop_on_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(slot_end));

  // R9
  upd_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && (DIV_W'(chg_dly) < div_val)) |-> !ph);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck_int && !lat_int);
endmodule

bind ledscan_drv ledscan_chk #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .clr_act(clr_act), .slot_end(slot_end),
  .sck_int(sck_int), .lat_int(lat_int), .ph(ph), .upd(upd),
  .div_val(div_val), .chg_dly(chg_dly));

// File: tb/ledscan_drv_tb.sv
module ledscan_drv_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         run_en, clr_req, geom16, single_led;
  logic [2:0]   ded_cnt;
  logic [23:0]  ded_val, inv_mask;
  logic [15:0]  div_val;
  logic [3:0]   chg_dly, hold_slots;
  logic [127:0] frame_data;
  logic         pol_sck, pol_sd, pol_lat;
  logic         sck_o, sd_o, lat_o;

  always #2 clk = ~clk;

  ledscan_drv u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .clr_req(clr_req), .geom16(geom16),
    .single_led(single_led), .ded_cnt(ded_cnt), .ded_val(ded_val), .inv_mask(inv_mask),
    .div_val(div_val), .chg_dly(chg_dly), .hold_slots(hold_slots), .frame_data(frame_data),
    .pol_sck(pol_sck), .pol_sd(pol_sd), .pol_lat(pol_lat),
    .sck_o(sck_o), .sd_o(sd_o), .lat_o(lat_o));

  int n_chk = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // pin decoder acting like an external register chain
  logic [23:0] sh;
  logic [23:0] words [0:127];
  int wtime [0:127];
  int nw = 0, lat_start = 0, lat_w = 0, last_fall = -100000, dly_seen = 0, dly_bad = 0;
  logic p_sck = 1'b0, p_sd = 1'b0, p_lat = 1'b0;

  always @(negedge clk) begin
    logic s, d, l;
    s = sck_o ^ pol_sck;
    d = sd_o ^ pol_sd;
    l = lat_o ^ pol_lat;
    if (s && !p_sck) sh = {sh[22:0], d};
    if (!s && p_sck) last_fall = cyc;
    if (d != p_sd && (cyc - last_fall) <= 2 * (int'(div_val) + 1)) begin
      dly_seen++;
      if (cyc - last_fall != int'(chg_dly) + 1) dly_bad++;
    end
    if (l && !p_lat) begin
      if (nw < 128) begin
        words[nw] = sh;
        wtime[nw] = cyc;
      end
      nw++;
      lat_start = cyc;
    end
    if (!l && p_lat) lat_w = cyc - lat_start;
    p_sck = s;
    p_sd  = d;
    p_lat = l;
  end

  function automatic int ncols(input bit g16, input int k);
    if (k == 7) return 1;
    if (g16) return (8 - k < 4) ? 8 - k : 4;
    return 8 - k;
  endfunction

  function automatic logic [23:0] model(input bit g16, input bit sgl, input int k, input int step,
                                        input logic [127:0] fd, input logic [23:0] inv,
                                        input logic [23:0] ded);
    int dw, subs, c, s, base;
    logic [23:0] w;
    dw   = g16 ? 16 : 8;
    subs = sgl ? dw : 1;
    c    = step / subs;
    s    = step % subs;
    base = g16 ? 0 : 8;
    w    = '0;
    for (int b = 0; b < dw; b++)
      if (fd[16 * c + b] && (!sgl || b == s)) w[24 - dw + b] = 1'b1;
    w[base + c] = 1'b1;
    for (int b = 0; b < 24; b++) begin
      if (k == 7 || (b >= base + 8 - k && b < base + 8)) w[b] = ded[b];
      else if (inv[b] && (g16 || b >= 8)) w[b] = ~w[b];
    end
    return w;
  endfunction

  task automatic idle_pins(input string req);
    chk(sck_o == pol_sck, req, "idle clock pin", 32'(sck_o), 32'(pol_sck));
    chk(sd_o == pol_sd, req, "idle data pin", 32'(sd_o), 32'(pol_sd));
    chk(lat_o == pol_lat, req, "idle latch pin", 32'(lat_o), 32'(pol_lat));
  endtask

  task automatic run_case(input string req, input bit g16, input bit sgl, input int k,
                          input bit clr_mid);
    int nst, steplen;
    geom16 = g16; single_led = sgl; ded_cnt = 3'(k);
    nst = ncols(g16, k) * (sgl ? (g16 ? 16 : 8) : 1);
    steplen = (int'(hold_slots) + 1) * 64 * (int'(div_val) + 1);
    repeat (4) @(negedge clk);
    nw = 0; dly_seen = 0; dly_bad = 0; last_fall = -100000;
    run_en = 1'b1;
    while (nw < 1) @(negedge clk);
    if (clr_mid) begin
      clr_req = 1'b1;
      @(negedge clk);
      clr_req = 1'b0;
    end
    run_en = 1'b0;
    repeat ((nst + 3) * steplen) @(negedge clk);
    // R10: frame completes, nothing after it
    chk(nw == nst, "R10", {req, " word count"}, 32'(nw), 32'(nst));
    for (int i = 0; i < nst && i < 128; i++)
      chk(words[i] == model(g16, sgl, k, i, frame_data, inv_mask, ded_val), req,
          $sformatf("word %0d", i), 32'(words[i]),
          32'(model(g16, sgl, k, i, frame_data, inv_mask, ded_val)));
    if (nst > 1)
      chk(wtime[1] - wtime[0] == steplen, "R2", "latch spacing",
          32'(wtime[1] - wtime[0]), 32'(steplen));
    chk(lat_w == 2 * (int'(div_val) + 1), "R8", "latch width", 32'(lat_w),
        32'(2 * (int'(div_val) + 1)));
    chk(dly_seen > 0 && dly_bad == 0, "R9", "data change lag", 32'(dly_bad), 32'(0));
    idle_pins("R1");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run_en = 1'b0; clr_req = 1'b0; geom16 = 1'b0; single_led = 1'b0;
    ded_cnt = '0; ded_val = '0; inv_mask = '0; div_val = 16'd1; chg_dly = 4'd0;
    hold_slots = 4'd1; pol_sck = 1'b0; pol_sd = 1'b0; pol_lat = 1'b0;
    for (int c = 0; c < 8; c++) frame_data[16 * c +: 16] = 16'h9D2B + 16'(c) * 16'h3117;
    repeat (3) @(negedge clk);
    chk({sck_o, sd_o, lat_o} == 3'b000, "R1", "pins in reset", 32'({sck_o, sd_o, lat_o}), 32'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    idle_pins("R1");

    run_case("R3", 1'b0, 1'b0, 0, 1'b0);            // 8x8 plain
    run_case("R4", 1'b1, 1'b0, 0, 1'b0);            // 16x4 plain
    inv_mask = 24'hC3A5FF;
    run_case("R5", 1'b0, 1'b0, 0, 1'b0);            // low mask byte ignored
    ded_val = 24'h5A5A5A;
    run_case("R6", 1'b0, 1'b0, 3, 1'b0);            // 5 columns
    run_case("R6", 1'b1, 1'b0, 2, 1'b0);            // free nibble dedicated
    run_case("R6", 1'b1, 1'b0, 6, 1'b0);            // 2 columns
    run_case("R6", 1'b0, 1'b0, 7, 1'b0);            // whole word
    run_case("R7", 1'b0, 1'b1, 0, 1'b0);
    run_case("R7", 1'b1, 1'b1, 1, 1'b0);
    hold_slots = 4'd3;
    run_case("R2", 1'b0, 1'b0, 0, 1'b0);
    hold_slots = 4'd1; div_val = 16'd3; chg_dly = 4'd2;
    run_case("R9", 1'b0, 1'b0, 2, 1'b0);
    div_val = 16'd1; chg_dly = 4'd0;
    run_case("R11", 1'b1, 1'b0, 0, 1'b1);           // clear ignored while running

    // R11: clear while stopped
    ded_cnt = 3'd2;
    repeat (4) @(negedge clk);
    nw = 0;
    clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    repeat (5 * 64 * (int'(div_val) + 1)) @(negedge clk);
    chk(nw == 1, "R11", "clear word count", 32'(nw), 32'(1));
    chk(words[0] == 24'h0, "R11", "clear word", 32'(words[0]), 32'(0));
    idle_pins("R11");

    // R12: pad polarity
    pol_sck = 1'b1; pol_sd = 1'b1; pol_lat = 1'b1;
    repeat (3) @(negedge clk);
    chk({sck_o, sd_o, lat_o} == 3'b111, "R12", "inverted idle pins",
        32'({sck_o, sd_o, lat_o}), 32'(7));
    run_case("R12", 1'b1, 1'b0, 1, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule